// File: doc/BRIEF.md
# One-Bit Stereo FIR Decimator

This block turns a pair of one-bit, 64x oversampled audio bitstreams (left and right) into filtered, multi-bit PCM words. It does this in a single filtering stage. Each input bit stands for +1 (bit high) or -1 (bit low), so every tap either adds or subtracts a coefficient, and no multiplier is needed. The coefficient set is symmetric, which gives linear phase. Only the first half of the set is stored; the second half is read through a mirrored index.

The block takes one bit per channel on every clock. At the end of each 64-clock frame it closes one window for each channel. The overlapping windows of neighbouring frames are held in a bank of running accumulators, one per 64 taps. A closed window is rounded to 18 or 16 bits, with saturation. Both words then leave on one serial line during the next frame: the left word in slots 0 to 31, the right word in slots 32 to 63, most significant bit first. An enable line marks the valid data bits and a channel line tells the halves apart.

DECIM must be a power of two and at least twice the wide word width. The coefficient function below keeps within 22 signed bits for tap counts up to a few thousand.

Top module: `fir1b_decim`

## Requirements
- R1: A frame is 64 clocks. In frame slots 0 to 31, `ser_rch` is 0 and the left word is sent. In slots 32 to 63, `ser_rch` is 1 and the right word is sent. The slot is the number of clocks since reset release, modulo 64.
- R2: Input samples are numbered from 0 at the first clock after reset release. The pre-rounding value for frame m is y = sum over k = 0..N-1 of h[k]*s(x[64m+63-k]), where h[k] = (k+1)*(N-k), N = NTAPS (default 255), s(1) = +1 and s(0) = -1. A sample taken before reset contributes 0.
- R3: In 18-bit mode the word is floor((y+8)/16). In 16-bit mode it is floor((y+32)/64).
- R4: The rounded result saturates to the signed range of the selected width: [-131072, 131071] or [-32768, 32767].
- R5: `wide_sel` is sampled only on the last clock of a frame (1 = 18 bits, 0 = 16 bits). That sample sets the width of both words sent in the next frame. `ser_en` is high in exactly the first 18 (or 16) slots of each half.
- R6: Words are sent in two's complement, most significant bit first, starting in slot 0 of their half.
- R7: After reset, and through the whole first frame, `ser_en` and `ser_dat` are 0.
- R8: The left and right channels are filtered independently; each word depends only on its own channel's bitstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_l | input | 1 | Left one-bit sample |
| bit_r | input | 1 | Right one-bit sample |
| wide_sel | input | 1 | Word width select, 1 = 18 bits, 0 = 16 bits |
| ser_dat | output | 1 | Serial PCM data, MSB first |
| ser_en | output | 1 | High while `ser_dat` carries a word bit |
| ser_rch | output | 1 | 0 during left half, 1 during right half |

## Verification
The assertions check on every cycle that:
- no window accumulator grows beyond the sum of the coefficient magnitudes;
- the latched words and width change only at a frame boundary;
- 16-bit words stay inside their range;
- the channel line switches at slot 32 and at slot 0;
- the serial line is quiet until a first frame is complete.

Whether each word equals the rounded, saturated convolution can only be shown by the bench. It does this by recomputing every frame from the bits it drove. Its scenarios cover steady ones and zeros that saturate both ways, alternating bits, pseudo-random bits, unequal densities on the two channels, and a width select that toggles inside frames.

// File: rtl/fir1b_pkg.sv
package fir1b_pkg;

    // Symmetric parabolic weight: w(k) == w(ntaps-1-k)
    function automatic int tap_weight(input int k, input int ntaps);
        return (k + 1) * (ntaps - k);
    endfunction

    // Sum of all weight magnitudes (weights are positive)
    function automatic longint weight_total(input int ntaps);
        longint s;
        s = 0;
        for (int k = 0; k < ntaps; k++) begin
            s = s + longint'(tap_weight(k, ntaps));
        end
        return s;
    endfunction

endpackage

// File: rtl/fir_coef_rom.sv
module fir_coef_rom
    import fir1b_pkg::*;
#(
    parameter int NTAPS  = 255,
    parameter int COEF_W = 22,
    parameter int NPORT  = 4,
    parameter int IDX_W  = 8
) (
    input  logic [NPORT-1:0][IDX_W-1:0]  idx,
    output logic [NPORT-1:0][COEF_W-1:0] coef
);
    // Only the first half of the symmetric set is stored
    localparam int HALF = (NTAPS + 1) / 2;

    function automatic logic [HALF*COEF_W-1:0] build_table();
        logic [HALF*COEF_W-1:0] t;
        t = '0;
        for (int k = 0; k < HALF; k++) begin
            t[k*COEF_W +: COEF_W] = COEF_W'(tap_weight(k, NTAPS));
        end
        return t;
    endfunction

    localparam logic [HALF*COEF_W-1:0] TABLE = build_table();

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [IDX_W-1:0] mir;
        always_comb begin
            if (int'(idx[p]) < HALF) begin
                mir = idx[p];
            end else if (int'(idx[p]) < NTAPS) begin
                mir = IDX_W'(NTAPS - 1) - idx[p];
            end else begin
                mir = '0;
            end
            coef[p] = TABLE[int'(mir)*COEF_W +: COEF_W];
        end
    end

endmodule

// File: rtl/fir_acc_bank.sv
module fir_acc_bank #(
    parameter int     NWIN   = 4,
    parameter int     DECIM  = 64,
    parameter int     COEF_W = 22,
    parameter int     ACC_W  = 31,
    parameter int     PH_W   = 6,
    parameter longint HSUM   = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bit_in,
    input  logic [PH_W-1:0]               ph,
    input  logic [NWIN-1:0][COEF_W-1:0]   coef,
    input  logic [NWIN-1:0]               tap_ok,
    output logic signed [ACC_W-1:0]       result
);
    typedef logic signed [ACC_W-1:0] acc_t;
    typedef struct packed {
        acc_t [NWIN-1:0] acc;
    } bank_s;

    localparam acc_t HSUM_A = acc_t'(HSUM);

    bank_s st_d, st_q;
    acc_t [NWIN-1:0] term;
    logic frame_end;

    // One-bit sample selects +h or -h; taps beyond the set add nothing
    for (genvar d = 0; d < NWIN; d++) begin : g_term
        acc_t cext;
        always_comb begin
            cext = acc_t'({{(ACC_W-COEF_W){coef[d][COEF_W-1]}}, coef[d]});
            if (!tap_ok[d]) begin
                term[d] = '0;
            end else if (bit_in) begin
                term[d] = cext;
            end else begin
                term[d] = -cext;
            end
        end
    end

    // Window d closes d frames from now; at a frame end all windows move down one slot
    always_comb begin
        frame_end = (ph == PH_W'(DECIM - 1));
        st_d      = st_q;
        result    = st_q.acc[0] + term[0];
        for (int d = 0; d < NWIN - 1; d++) begin
            if (frame_end) begin
                st_d.acc[d] = st_q.acc[d+1] + term[d+1];
            end else begin
                st_d.acc[d] = st_q.acc[d] + term[d];
            end
        end
        if (frame_end) begin
            st_d.acc[NWIN-1] = '0;
        end else begin
            st_d.acc[NWIN-1] = st_q.acc[NWIN-1] + term[NWIN-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar d = 0; d < NWIN; d++) begin : g_chk
        // R2: a partial window never exceeds the total weight magnitude
        assert_acc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.acc[d] <= HSUM_A) && (st_q.acc[d] >= -HSUM_A));
    end

endmodule

// File: rtl/pcm_round_sat.sv
module pcm_round_sat #(
    parameter int ACC_W    = 31,
    parameter int SHIFT    = 4,
    parameter int W_WIDE   = 18,
    parameter int W_NARROW = 16
) (
    input  logic signed [ACC_W-1:0]  acc,
    input  logic                     wide,
    output logic signed [W_WIDE-1:0] word
);
    localparam int SHIFT_N = SHIFT + W_WIDE - W_NARROW;

    typedef logic signed [ACC_W:0] ext_t;

    localparam ext_t RND_W = ext_t'(1) <<< (SHIFT - 1);
    localparam ext_t RND_N = ext_t'(1) <<< (SHIFT_N - 1);
    localparam ext_t MAX_W = (ext_t'(1) <<< (W_WIDE - 1)) - ext_t'(1);
    localparam ext_t MAX_N = (ext_t'(1) <<< (W_NARROW - 1)) - ext_t'(1);

    ext_t ax, rw, rn, r, hi, lo, rs;

    // R3 round half up, R4 clamp to the selected range
    always_comb begin
        ax = ext_t'(acc);
        rw = (ax + RND_W) >>> SHIFT;
        rn = (ax + RND_N) >>> SHIFT_N;
        r  = wide ? rw : rn;
        hi = wide ? MAX_W : MAX_N;
        lo = ~hi;
        if (r > hi) begin
            rs = hi;
        end else if (r < lo) begin
            rs = lo;
        end else begin
            rs = r;
        end
        word = rs[W_WIDE-1:0];
    end

endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx #(
    parameter int W_WIDE   = 18,
    parameter int W_NARROW = 16,
    parameter int PH_W     = 6
) (
    input  logic [PH_W-1:0]   ph,
    input  logic              have,
    input  logic              wide,
    input  logic [W_WIDE-1:0] wl,
    input  logic [W_WIDE-1:0] wr,
    output logic              sdat,
    output logic              sen,
    output logic              srch
);
    localparam int SLOT_W = PH_W - 1;

    logic [SLOT_W-1:0] b, len, pos;
    logic [W_WIDE-1:0] w;

    // Upper half of the frame carries the right word, MSB first
    always_comb begin
        srch = ph[PH_W-1];
        b    = ph[SLOT_W-1:0];
        w    = srch ? wr : wl;
        len  = wide ? SLOT_W'(W_WIDE) : SLOT_W'(W_NARROW);
        sen  = have && (b < len);
        pos  = len - SLOT_W'(1) - b;
        sdat = sen ? w[pos] : 1'b0;
    end

endmodule

// File: rtl/fir1b_decim.sv
module fir1b_decim
    import fir1b_pkg::*;
#(
    parameter int NTAPS    = 255,
    parameter int DECIM    = 64,
    parameter int COEF_W   = 22,
    parameter int W_WIDE   = 18,
    parameter int W_NARROW = 16,
    parameter int SHIFT    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_l,
    input  logic bit_r,
    input  logic wide_sel,
    output logic ser_dat,
    output logic ser_en,
    output logic ser_rch
);
    localparam int     PH_W       = $clog2(DECIM);
    localparam int     NWIN       = (NTAPS + DECIM - 1) / DECIM;
    localparam int     IDX_W      = $clog2(NWIN * DECIM);
    localparam int     ACC_W      = COEF_W + $clog2(NTAPS) + 1;
    localparam longint HSUM       = weight_total(NTAPS);
    localparam int     HALF_SLOTS = DECIM / 2;

    typedef logic signed [W_WIDE-1:0] word_t;
    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            have;
        logic            wide;
        word_t           wl;
        word_t           wr;
    } top_s;

    localparam word_t N_MAX = word_t'((1 << (W_NARROW - 1)) - 1);
    localparam word_t N_MIN = ~N_MAX;

    top_s st_d, st_q;

    logic [NWIN-1:0][IDX_W-1:0]  tap_idx;
    logic [NWIN-1:0]             tap_ok;
    logic [NWIN-1:0][COEF_W-1:0] coef;
    logic                        frame_end;
    logic [1:0]                  bits;
    word_t                       word_new [2];

    assign bits      = {bit_r, bit_l};
    assign frame_end = (st_q.ph == PH_W'(DECIM - 1));

    // Tap index seen by window d for the bit arriving now
    for (genvar d = 0; d < NWIN; d++) begin : g_tap
        assign tap_idx[d] = IDX_W'(d * DECIM + DECIM - 1) - IDX_W'(st_q.ph);
        assign tap_ok[d]  = ({1'b0, tap_idx[d]} < (IDX_W + 1)'(NTAPS));
    end

    fir_coef_rom #(
        .NTAPS (NTAPS),
        .COEF_W(COEF_W),
        .NPORT (NWIN),
        .IDX_W (IDX_W)
    ) u_rom (
        .idx (tap_idx),
        .coef(coef)
    );

    for (genvar c = 0; c < 2; c++) begin : g_ch
        logic signed [ACC_W-1:0] result;

        fir_acc_bank #(
            .NWIN  (NWIN),
            .DECIM (DECIM),
            .COEF_W(COEF_W),
            .ACC_W (ACC_W),
            .PH_W  (PH_W),
            .HSUM  (HSUM)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .bit_in(bits[c]),
            .ph    (st_q.ph),
            .coef  (coef),
            .tap_ok(tap_ok),
            .result(result)
        );

        pcm_round_sat #(
            .ACC_W   (ACC_W),
            .SHIFT   (SHIFT),
            .W_WIDE  (W_WIDE),
            .W_NARROW(W_NARROW)
        ) u_rnd (
            .acc (result),
            .wide(wide_sel),
            .word(word_new[c])
        );
    end

    // Width and both words latch together at the frame end (R5)
    always_comb begin
        st_d    = st_q;
        st_d.ph = frame_end ? '0 : st_q.ph + PH_W'(1);
        if (frame_end) begin
            st_d.have = 1'b1;
            st_d.wide = wide_sel;
            st_d.wl   = word_new[0];
            st_d.wr   = word_new[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    pcm_serial_tx #(
        .W_WIDE  (W_WIDE),
        .W_NARROW(W_NARROW),
        .PH_W    (PH_W)
    ) u_tx (
        .ph  (st_q.ph),
        .have(st_q.have),
        .wide(st_q.wide),
        .wl  (st_q.wl),
        .wr  (st_q.wr),
        .sdat(ser_dat),
        .sen (ser_en),
        .srch(ser_rch)
    );

    assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(st_q.wl) && $stable(st_q.wr) && $stable(st_q.wide)));

    assert_rch_right_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_W'(HALF_SLOTS - 1)) |=> ser_rch);

    assert_rch_left_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !ser_rch);

    assert_narrow_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.have && !st_q.wide) |->
            ($signed(st_q.wl) <= N_MAX && $signed(st_q.wl) >= N_MIN &&
             $signed(st_q.wr) <= N_MAX && $signed(st_q.wr) >= N_MIN));

    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.have |-> (!ser_en && !ser_dat));

endmodule

// File: tb/sim_fir1b_decim.sv
module sim_fir1b_decim;
    localparam int N      = 255;
    localparam int D      = 64;
    localparam int FRAMES = 41;
    localparam int TOTAL  = FRAMES * D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_l = 1'b0;
    logic bit_r = 1'b0;
    logic wide_sel = 1'b1;
    logic ser_dat, ser_en, ser_rch;

    // 10 time units per period: 100 MHz at 1 ns units
    always #5 clk = ~clk;

    fir1b_decim u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_l   (bit_l),
        .bit_r   (bit_r),
        .wide_sel(wide_sel),
        .ser_dat (ser_dat),
        .ser_en  (ser_en),
        .ser_rch (ser_rch)
    );

    bit     sb [2][TOTAL];
    bit     wsel [FRAMES];
    int     total = 0;
    int     bad = 0;
    bit     done = 1'b0;
    longint rx [2];

    function automatic bit gen_bit(int ch, int n);
        int seg;
        int hsh;
        seg = (n / 512) % 5;
        hsh = (n * 1103515245 + 12345 + ch * 7919) >>> 9;
        case (seg)
            0: return 1'b1;
            1: return 1'b0;
            2: return (ch == 0) ? n[0] : ~n[0];
            3: return hsh[3];
            default: return (ch == 0) ? (n % 4 != 0) : (n % 4 == 0);
        endcase
    endfunction

    // R2/R3/R4 reference arithmetic
    function automatic longint expect_word(int ch, int m, bit w);
        longint acc, h, r, hi;
        int n, sh;
        acc = 0;
        for (int k = 0; k < N; k++) begin
            n = m * D + D - 1 - k;
            if (n >= 0) begin
                h = longint'(k + 1) * longint'(N - k);
                acc = sb[ch][n] ? acc + h : acc - h;
            end
        end
        sh = w ? 4 : 6;
        r  = (acc + (longint'(1) <<< (sh - 1))) >>> sh;
        hi = w ? 131071 : 32767;
        if (r > hi) r = hi;
        if (r < -hi - 1) r = -hi - 1;
        return r;
    endfunction

    task automatic check(bit ok, string tag, longint got, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    initial begin
        int s, m, len, b, ch;
        longint got, exp;
        for (int n = 0; n < TOTAL; n++) begin
            sb[0][n] = gen_bit(0, n);
            sb[1][n] = gen_bit(1, n);
        end
        for (int f = 0; f < FRAMES; f++) wsel[f] = (f % 3 != 1);
        rx[0] = 0;
        rx[1] = 0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R7: reset state
        check(!ser_en && !ser_dat, "R7 reset", {ser_en, ser_dat}, 0);
        rst_n = 1'b1;

        for (int n = 0; n < TOTAL; n++) begin
            s = n % D;
            if (n < D) begin
                check(!ser_en && !ser_dat, "R7 first frame", {ser_en, ser_dat}, 0);
            end else begin
                m   = n / D - 1;
                len = wsel[m] ? 18 : 16;
                ch  = (s >= 32) ? 1 : 0;
                b   = s % 32;
                check(ser_rch == ch[0], "R1 channel", ser_rch, ch);
                check(ser_en == (b < len), "R5 enable", ser_en, (b < len));
                if (b < len) begin
                    rx[ch] = (rx[ch] <<< 1) | longint'(ser_dat);
                    if (b == len - 1) begin
                        got = rx[ch];
                        if (got[len-1]) got = got - (longint'(1) <<< len);
                        exp = expect_word(ch, m, wsel[m]);
                        // R2 R3 R4 R6 R8: per-channel word value
                        check(got == exp, (ch == 0) ? "R2/R3/R4/R6 left" : "R8 right word",
                              got, exp);
                        rx[ch] = 0;
                    end
                end
            end
            bit_l    = sb[0][n];
            bit_r    = sb[1][n];
            wide_sel = (s == D - 1) ? wsel[n / D] : ~wsel[n / D];
            @(negedge clk);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog got=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule